// File: doc/BRIEF.md
# Elastic Sample Buffer with Phase-Strobe Alignment

This block carries a stream of samples, together with a one-bit phase-alignment strobe, from an input clock domain into an output clock domain. On the input side a capture stage registers the sample word. It registers the strobe on either the rising or the falling edge of the input clock, as a configuration bit selects. The captured pair then passes through an eight-entry elastic buffer. Its write pointer runs on the input clock and its read pointer runs on the output clock, so slow phase drift between the two clocks is absorbed. A bypass route lets the pair skip the buffer and be registered straight into the output domain. Selecting the on-chip-PLL clock mode always forces that route.

In the output domain the strobe drives a numerically controlled oscillator's phase accumulator. Each output cycle the accumulator either adds a frequency word or, when the strobe is present, returns to zero. The buffer can be re-centred at any time by an initialisation request. The request places the read side half the depth behind the write side and clears a sticky collision flag. That flag rises whenever either side sees the pointers meet, which signals an overrun or an underrun.

Top module: `sefn_top`

## Requirements
- R1: After both resets are released, out_phase is 0 while nco_freq is 0, and out_err is 0.
- R2: With the buffer in use and both clocks at the same rate, out_data repeats the input samples in order, each sample exactly once, so successive values step by one when the input counts up.
- R3: In every output cycle without a strobe, out_phase grows by nco_freq, modulo 2^32.
- R4: A strobe that reaches the accumulator sets out_phase to 0 in place of that cycle's addition. The following cycle then shows exactly nco_freq.
- R5: With cfg_strobe_inv = 0 the strobe is sampled on the rising edge of in_clk. With cfg_strobe_inv = 1 it is sampled on the falling edge. A pulse that is high only across a falling edge has no effect on out_phase while cfg_strobe_inv = 0.
- R6: With the buffer in use, out_phase first reads 0 no sooner than 5 and no later than 12 output cycles after the strobe is applied.
- R7: With cfg_bypass = 1, out_phase reads 0 within 3 output cycles of the strobe being applied, and out_data still steps by one per cycle.
- R8: With cfg_pll_mode = 1 the bypass route is used whatever cfg_bypass holds, so the 3-cycle bound of R7 applies.
- R9: When the pointers collide (for example, the input clock stops while reads go on), out_err rises and stays at 1 even after the input clock resumes.
- R10: Asserting fifo_init clears out_err and re-centres the buffer, after which out_data again steps by one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input-domain clock |
| in_rst | input | 1 | Synchronous active-high reset, input domain |
| in_data | input | 16 | Sample word written on in_clk |
| in_strobe | input | 1 | Phase-alignment strobe |
| out_clk | input | 1 | Output-domain clock |
| out_rst | input | 1 | Synchronous active-high reset, output domain |
| cfg_bypass | input | 1 | 1 routes samples and strobe around the buffer |
| cfg_strobe_inv | input | 1 | 0 samples the strobe on the rising in_clk edge, 1 on the falling edge |
| cfg_pll_mode | input | 1 | 1 selects the PLL clock mode, which forces the bypass route |
| fifo_init | input | 1 | Level request to re-centre the buffer and clear the collision flag |
| nco_freq | input | 32 | Frequency word added to the accumulator each output cycle |
| out_data | output | 16 | Sample word in the output domain |
| out_phase | output | 32 | Phase accumulator value |
| out_err | output | 1 | Sticky pointer-collision flag |

## Verification
In a single output cycle the accumulator can be called on both to add the frequency word and to clear on an arriving strobe. The clear must win, and it must not swallow the next step. The bench drives strobe pulses, aligned to either clock edge, while a nonzero odd frequency word is running. Odd words keep the phase from ever reaching zero by accumulation alone. The bench then requires that the first zero lands inside the latency window of the selected route, that the very next sample equals the frequency word, and that every other sample is exactly one word above its predecessor.

// File: rtl/sefn_pkg.sv
package sefn_pkg;

    localparam int SAMPLE_W     = 16;
    localparam int PHASE_W      = 32;
    localparam int FIFO_DEPTH   = 8;
    localparam int ADDR_W       = $clog2(FIFO_DEPTH);
    localparam int PTR_W        = ADDR_W + 1;
    localparam int GUARD_CYCLES = 4;
    localparam int GUARD_W      = $clog2(GUARD_CYCLES + 1);

    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        logic                strobe;
        logic [SAMPLE_W-1:0] data;
    } sample_t;

    localparam ptr_t HALF_PTR = ptr_t'(FIFO_DEPTH / 2);

    function automatic ptr_t bin2gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/sefn_sync.sv
module sefn_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/sefn_capture.sv
module sefn_capture
    import sefn_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe_inv,
    input  logic [SAMPLE_W-1:0] data_in,
    input  logic                strobe_in,
    output sample_t             cap_q
);

    logic fall_q;

    // falling-edge sample of the strobe, held for the following rising edge
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= strobe_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.data   <= data_in;
            cap_q.strobe <= strobe_inv ? fall_q : strobe_in;
        end
    end

endmodule

// File: rtl/sefn_elastic.sv
module sefn_elastic
    import sefn_pkg::*;
(
    input  logic    wr_clk,
    input  logic    wr_rst,
    input  sample_t wr_sample,
    input  logic    rd_clk,
    input  logic    rd_rst,
    input  logic    init_req,
    output sample_t rd_sample,
    output logic    rd_init,
    output logic    rd_err,
    output logic    wr_err_synced
);

    sample_t mem [FIFO_DEPTH];

    // write-domain state
    logic               wi_s;
    logic               wi_d;
    logic               w_init;
    ptr_t               wptr;
    ptr_t               wgray;
    ptr_t               rgray_w;
    ptr_t               rbin_w;
    ptr_t               wfill;
    logic [GUARD_W-1:0] wguard;
    logic               werr;

    // read-domain state
    logic               ri_s;
    logic               ri_d;
    ptr_t               rptr;
    ptr_t               rgray;
    ptr_t               wgray_r;
    ptr_t               wbin_r;
    ptr_t               rfill;
    logic               r_collide;
    logic [GUARD_W-1:0] rguard;

    sefn_sync #(.W(1), .RST_VAL(1'b0)) u_init_w (
        .clk(wr_clk), .rst(wr_rst), .d(init_req), .q(wi_s)
    );
    sefn_sync #(.W(PTR_W), .RST_VAL(bin2gray(ptr_t'(0)))) u_rgray_w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_w)
    );
    sefn_sync #(.W(1), .RST_VAL(1'b0)) u_init_r (
        .clk(rd_clk), .rst(rd_rst), .d(init_req), .q(ri_s)
    );
    sefn_sync #(.W(PTR_W), .RST_VAL(bin2gray(HALF_PTR))) u_wgray_r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_r)
    );
    sefn_sync #(.W(1), .RST_VAL(1'b0)) u_werr_r (
        .clk(rd_clk), .rst(rd_rst), .d(werr), .q(wr_err_synced)
    );

    assign w_init = wi_s & ~wi_d;
    assign rbin_w = gray2bin(rgray_w);
    assign wfill  = wptr - rbin_w;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wptr   <= HALF_PTR;
            wgray  <= bin2gray(HALF_PTR);
            wi_d   <= 1'b0;
            werr   <= 1'b0;
            wguard <= '0;
            for (int i = 0; i < FIFO_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            wi_d <= wi_s;
            if (w_init) begin
                wptr   <= HALF_PTR;
                wgray  <= bin2gray(HALF_PTR);
                werr   <= 1'b0;
                wguard <= GUARD_W'(GUARD_CYCLES);
            end else begin
                mem[wptr[ADDR_W-1:0]] <= wr_sample;
                wptr  <= wptr + 1'b1;
                wgray <= bin2gray(wptr + 1'b1);
                if (wguard != '0) begin
                    wguard <= wguard - 1'b1;
                end else if (wfill[PTR_W-1]) begin
                    werr <= 1'b1;
                end
            end
        end
    end

    assign rd_init   = ri_s & ~ri_d;
    assign wbin_r    = gray2bin(wgray_r);
    assign rfill     = wbin_r - rptr;
    assign r_collide = (rfill == '0) | rfill[PTR_W-1];

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rptr      <= '0;
            rgray     <= '0;
            ri_d      <= 1'b0;
            rd_err    <= 1'b0;
            rguard    <= '0;
            rd_sample <= '0;
        end else begin
            ri_d <= ri_s;
            if (rd_init) begin
                rptr   <= '0;
                rgray  <= '0;
                rd_err <= 1'b0;
                rguard <= GUARD_W'(GUARD_CYCLES);
            end else begin
                rd_sample <= mem[rptr[ADDR_W-1:0]];
                rptr      <= rptr + 1'b1;
                rgray     <= bin2gray(rptr + 1'b1);
                if (rguard != '0) begin
                    rguard <= rguard - 1'b1;
                end else if (r_collide) begin
                    rd_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sefn_nco.sv
module sefn_nco #(
    parameter int ACC_W = sefn_pkg::PHASE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [ACC_W-1:0] freq,
    output logic [ACC_W-1:0] phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else begin
            phase <= phase + freq;
        end
    end

endmodule

// File: rtl/sefn_top.sv
module sefn_top
    import sefn_pkg::*;
(
    input  logic                in_clk,
    input  logic                in_rst,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_strobe,
    input  logic                out_clk,
    input  logic                out_rst,
    input  logic                cfg_bypass,
    input  logic                cfg_strobe_inv,
    input  logic                cfg_pll_mode,
    input  logic                fifo_init,
    input  logic [PHASE_W-1:0]  nco_freq,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [PHASE_W-1:0]  out_phase,
    output logic                out_err
);

    sample_t cap_q;
    sample_t fifo_q;
    sample_t out_s;
    logic    bypass_eff;
    logic    out_stb;
    logic    fifo_rd_init;
    logic    fifo_rd_err;
    logic    fifo_wr_err;

    sefn_capture u_capture (
        .clk        (in_clk),
        .rst        (in_rst),
        .strobe_inv (cfg_strobe_inv),
        .data_in    (in_data),
        .strobe_in  (in_strobe),
        .cap_q      (cap_q)
    );

    sefn_elastic u_elastic (
        .wr_clk        (in_clk),
        .wr_rst        (in_rst),
        .wr_sample     (cap_q),
        .rd_clk        (out_clk),
        .rd_rst        (out_rst),
        .init_req      (fifo_init),
        .rd_sample     (fifo_q),
        .rd_init       (fifo_rd_init),
        .rd_err        (fifo_rd_err),
        .wr_err_synced (fifo_wr_err)
    );

    // the PLL clock mode cannot run through the buffer
    assign bypass_eff = cfg_bypass | cfg_pll_mode;

    always_ff @(posedge out_clk) begin
        if (out_rst) begin
            out_s <= '0;
        end else begin
            out_s <= bypass_eff ? cap_q : fifo_q;
        end
    end

    assign out_stb  = out_s.strobe;
    assign out_data = out_s.data;
    assign out_err  = fifo_rd_err | fifo_wr_err;

    sefn_nco #(.ACC_W(PHASE_W)) u_nco (
        .clk   (out_clk),
        .rst   (out_rst),
        .clear (out_stb),
        .freq  (nco_freq),
        .phase (out_phase)
    );

endmodule

// File: rtl/sefn_checker.sv
module sefn_checker
    import sefn_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               stb,
    input logic [PHASE_W-1:0] phase,
    input logic [PHASE_W-1:0] freq,
    input logic               rd_init,
    input logic               rd_err
);

    a_r1_phase_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> phase == '0);

    a_r3_accumulates: assert property (@(posedge clk) disable iff (rst)
        !stb |=> phase == $past(phase) + $past(freq));

    a_r4_strobe_clears: assert property (@(posedge clk) disable iff (rst)
        stb |=> phase == '0);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (rd_err && !rd_init) |=> rd_err);

    a_r10_init_clears: assert property (@(posedge clk) disable iff (rst)
        rd_init |=> !rd_err);

endmodule

bind sefn_top sefn_checker u_chk (
    .clk     (out_clk),
    .rst     (out_rst),
    .stb     (out_stb),
    .phase   (out_phase),
    .freq    (nco_freq),
    .rd_init (fifo_rd_init),
    .rd_err  (fifo_rd_err)
);

// File: tb/tb_sefn_top.sv
module tb_sefn_top;

    logic        in_clk;
    logic        in_rst;
    logic [15:0] in_data;
    logic        in_strobe;
    logic        out_clk;
    logic        out_rst;
    logic        cfg_bypass;
    logic        cfg_strobe_inv;
    logic        cfg_pll_mode;
    logic        fifo_init;
    logic [31:0] nco_freq;
    logic [15:0] out_data;
    logic [31:0] out_phase;
    logic        out_err;
    logic        in_run;
    int          n_checks;
    int          n_fail;
    bit          done;

    // vector: [39] bypass, [38] pll, [37] inv, [36] fall-only pulse,
    // [35:34] expectation (0 no clear, 1 fast route, 2 buffered route), [31:0] freq
    localparam logic [39:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'b00, 32'h0100_0001},
        {1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'b00, 32'h0123_4567},
        {1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 32'h0000_1003},
        {1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 32'h1000_0001},
        {1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 2'b00, 32'h0F0F_0F0F},
        {1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'b00, 32'h0000_0777},
        {1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 2'b00, 32'h0000_0003},
        {1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'b00, 32'h0000_0101}
    };

    sefn_top dut (
        .in_clk(in_clk), .in_rst(in_rst), .in_data(in_data), .in_strobe(in_strobe),
        .out_clk(out_clk), .out_rst(out_rst), .cfg_bypass(cfg_bypass),
        .cfg_strobe_inv(cfg_strobe_inv), .cfg_pll_mode(cfg_pll_mode),
        .fifo_init(fifo_init), .nco_freq(nco_freq), .out_data(out_data),
        .out_phase(out_phase), .out_err(out_err)
    );

    initial begin
        in_clk = 1'b0;
        forever #5 in_clk = in_run ? ~in_clk : 1'b0;
    end

    initial begin
        out_clk = 1'b0;
        #3;
        forever #5 out_clk = ~out_clk;
    end

    initial begin
        in_data = 16'd0;
        forever begin
            @(posedge in_clk);
            #1 in_data = in_data + 16'd1;
        end
    end

    task automatic check(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_order(input string tag);
        logic [15:0] prevd;
        int          bad;
        bad = 0;
        @(negedge out_clk);
        prevd = out_data;
        for (int k = 0; k < 20; k++) begin
            @(negedge out_clk);
            if (out_data != prevd + 16'd1) bad++;
            prevd = out_data;
        end
        check(tag, bad == 0, 64'(bad), 64'd0);
    endtask

    logic [31:0] prev_ph;
    logic [31:0] cur_ph;
    logic [31:0] after_ph;
    logic [31:0] freq_v;
    int          first_zero;
    int          step_bad;
    bit          after_seen;
    bit          fall_only;
    logic [1:0]  expect_kind;
    string       tag;
    bit          lat_ok;

    initial begin
        n_checks = 0; n_fail = 0; done = 1'b0;
        in_run = 1'b1; in_rst = 1'b1; out_rst = 1'b1; in_strobe = 1'b0;
        cfg_bypass = 1'b0; cfg_strobe_inv = 1'b0; cfg_pll_mode = 1'b0;
        fifo_init = 1'b0; nco_freq = 32'd0;
        repeat (5) @(posedge in_clk);
        #1;
        in_rst = 1'b0;
        out_rst = 1'b0;

        // R1: reset state
        repeat (3) @(negedge out_clk);
        check("R1 phase", out_phase == 32'd0, 64'(out_phase), 64'd0);
        check("R1 err", out_err == 1'b0, 64'(out_err), 64'd0);

        // R2: buffered stream keeps order
        repeat (20) @(negedge out_clk);
        check_order("R2");

        // vector table
        for (int v = 0; v < 8; v++) begin
            cfg_bypass     = VEC[v][39];
            cfg_pll_mode   = VEC[v][38];
            cfg_strobe_inv = VEC[v][37];
            fall_only      = VEC[v][36];
            expect_kind    = VEC[v][35:34];
            freq_v         = VEC[v][31:0];
            nco_freq       = freq_v;
            if (expect_kind == 2'd0)                       tag = "R5";
            else if (expect_kind == 2'd1 && VEC[v][38])    tag = "R8";
            else if (expect_kind == 2'd1)                  tag = "R7";
            else if (fall_only)                            tag = "R5";
            else                                           tag = "R6";
            repeat (20) @(negedge out_clk);
            prev_ph = out_phase;
            first_zero = 0; step_bad = 0; after_seen = 1'b0; after_ph = 32'd0;
            @(posedge in_clk);
            #1;
            fork
                begin
                    in_strobe = 1'b1;
                    if (fall_only) @(negedge in_clk);
                    else           @(posedge in_clk);
                    #1 in_strobe = 1'b0;
                end
                begin
                    for (int n = 1; n <= 14; n++) begin
                        @(negedge out_clk);
                        cur_ph = out_phase;
                        if (cur_ph == 32'd0) begin
                            if (first_zero == 0) first_zero = n;
                        end else if (prev_ph == 32'd0 && first_zero != 0 && !after_seen) begin
                            after_seen = 1'b1;
                            after_ph   = cur_ph;
                        end else if (cur_ph != prev_ph + freq_v) begin
                            step_bad++;
                        end
                        prev_ph = cur_ph;
                    end
                end
            join
            case (expect_kind)
                2'd0:    lat_ok = (first_zero == 0);
                2'd1:    lat_ok = (first_zero >= 1 && first_zero <= 3);
                default: lat_ok = (first_zero >= 5 && first_zero <= 12);
            endcase
            check({tag, " latency"}, lat_ok, 64'(first_zero), 64'(expect_kind));
            check("R3 step", step_bad == 0, 64'(step_bad), 64'd0);
            if (expect_kind != 2'd0) begin
                check("R4 after clear", after_seen && after_ph == freq_v, 64'(after_ph), 64'(freq_v));
            end
        end

        // R7: bypass stream order
        cfg_bypass = 1'b1; cfg_pll_mode = 1'b0;
        repeat (5) @(negedge out_clk);
        check_order("R7 order");
        cfg_bypass = 1'b0;
        repeat (20) @(negedge out_clk);
        check("R9 no err before", out_err == 1'b0, 64'(out_err), 64'd0);

        // R9: stop input clock -> underrun
        @(posedge in_clk);
        #1 in_run = 1'b0;
        repeat (30) @(negedge out_clk);
        check("R9 raised", out_err == 1'b1, 64'(out_err), 64'd1);
        in_run = 1'b1;
        repeat (20) @(negedge out_clk);
        check("R9 sticky", out_err == 1'b1, 64'(out_err), 64'd1);

        // R10: re-initialisation
        fifo_init = 1'b1;
        repeat (6) @(negedge out_clk);
        fifo_init = 1'b0;
        repeat (30) @(negedge out_clk);
        check("R10 err cleared", out_err == 1'b0, 64'(out_err), 64'd0);
        check_order("R10 order");
        check("R10 err stays clear", out_err == 1'b0, 64'(out_err), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule